// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block stands between a microcontroller's special-function-register write bus and an on-chip flash array, modelled here as a byte memory. Software starts an erase in two steps. It first loads an arming value, which is either the mass-erase enable bit or a page number. It then writes a key byte to a single trigger register. The block accepts the erase only when the key matches the armed operation and the preconditions hold. For a mass erase the debug port must be enabled, and for any flash change the measurement coprocessor must be off.

Byte programming goes through a separate write port. It can only pull bits low: the stored byte becomes the AND of its old value and the new data. An erase drives every byte of the selected page, or of the whole array, back to 0xFF. After an accepted erase, a busy flag stays high for a programmable number of cycles, and the block ignores all program and trigger requests during that time. In production the pages are 1024 bytes and the array holds 32 KB; the default parameters shrink the page so the model stays small.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy and mass_armed are 0 and every byte of the array reads 0xFF.
- R2: A byte program with busy low and cp_en low stores old AND new data, so no bit can return from 0 to 1. The result is readable from the cycle after the write edge.
- R3: Writing the page number into bits [7:1] of SFR 0xB7 and then 0x55 to SFR 0x94 sets every byte of that page to 0xFF. Bytes in other pages are left unchanged.
- R4: Writing 1 to bit 1 of SFR 0xB2 and then 0xAA to SFR 0x94, with dbg_en high, sets every byte of the array to 0xFF.
- R5: A 0xAA trigger with mass erase armed but dbg_en low changes no byte, leaves busy low, and clears mass_armed.
- R6: A trigger byte other than 0xAA or 0x55, or a key whose matching arming step is missing, changes no byte and leaves busy low. An accepted 0x55 consumes the page arming.
- R7: A page number of NUM_PAGES or above erases nothing and leaves busy low.
- R8: busy rises on the edge that accepts an erase and stays high for exactly ERASE_CYCLES cycles.
- R9: Byte programs and trigger writes that arrive while busy is high have no effect.
- R10: While cp_en is high, byte programs and erase triggers change nothing.
- R11: mass_armed returns to 0 on the edge where a mass erase's busy period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address (0xB2 control, 0xB7 page, 0x94 trigger) |
| sfr_wdata | input | 8 | SFR write data |
| dbg_en | input | 1 | Debug port enabled; required for mass erase |
| cp_en | input | 1 | Measurement coprocessor running; blocks flash changes |
| prog_we | input | 1 | Byte program request |
| prog_addr | input | ADDR_W (10) | Byte program address |
| prog_data | input | 8 | Byte program data |
| rd_addr | input | ADDR_W (10) | Read address |
| rd_data | output | 8 | Byte at rd_addr (combinational) |
| busy | output | 1 | Erase in progress |
| mass_armed | output | 1 | Mass-erase enable bit |

## Verification
The read port is combinational. A byte program or an erase therefore shows up at rd_data immediately after the clock edge that samples the request. busy rises on that same edge and falls ERASE_CYCLES edges later, and mass_armed falls on that final edge. The bench drives inputs 1 ns after a rising edge and updates a behavioural model on each rising edge. It compares busy, mass_armed and the addressed byte with the model on every falling edge. Directed checks read bytes 1 ns after a rising edge and count the busy cycles edge by edge, so every sample lands after the edge on which the result is due.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] SFR_CTRL = 8'hB2;
    localparam logic [7:0] SFR_PAGE = 8'hB7;
    localparam logic [7:0] SFR_TRIG = 8'h94;
    localparam logic [7:0] KEY_MASS = 8'hAA;
    localparam logic [7:0] KEY_PAGE = 8'h55;
    localparam int         PAGE_W   = 7;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PAGE = 2'd1,
        OP_MASS = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [PAGE_W-1:0] page;
    } erase_cmd_t;

    function automatic logic page_in_range(input logic [PAGE_W-1:0] pg, input int n);
        return int'(pg) < n;
    endfunction

endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic              ctrl_bit,
    input  logic [PAGE_W-1:0] page_field,
    input  logic              clr_mass,
    input  logic              clr_page,
    output logic              mass_armed,
    output logic              page_armed,
    output logic [PAGE_W-1:0] page_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mass_armed <= 1'b0;
            page_armed <= 1'b0;
            page_sel   <= '0;
        end else begin
            if (clr_mass) mass_armed <= 1'b0;
            if (clr_page) page_armed <= 1'b0;
            if (sfr_we) begin
                case (sfr_addr)
                    SFR_CTRL: mass_armed <= ctrl_bit;
                    SFR_PAGE: begin
                        page_sel   <= page_field;
                        page_armed <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
    import flash_seq_pkg::*;
#(
    parameter int NUM_PAGES    = 32,
    parameter int ERASE_CYCLES = 16,
    localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_we,
    input  logic [7:0]        trig_data,
    input  logic              mass_armed,
    input  logic              page_armed,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              dbg_en,
    input  logic              cp_en,
    output logic              go,
    output erase_cmd_t        cmd,
    output logic              busy,
    output logic              clr_mass,
    output logic              clr_page,
    output op_e               cur_op
);

    logic [CNT_W-1:0] cnt;
    logic             last_cycle;

    assign busy       = (cnt != '0);
    assign last_cycle = (cnt == CNT_W'(1));

    always_comb begin
        go       = 1'b0;
        cmd      = '{op: OP_NONE, page: page_sel};
        clr_mass = 1'b0;
        clr_page = 1'b0;
        if (trig_we && !busy) begin
            if (trig_data == KEY_MASS && mass_armed) begin
                if (dbg_en && !cp_en) begin
                    go     = 1'b1;
                    cmd.op = OP_MASS;
                end else begin
                    clr_mass = 1'b1;
                end
            end else if (trig_data == KEY_PAGE && page_armed) begin
                clr_page = 1'b1;
                if (page_in_range(page_sel, NUM_PAGES) && !cp_en) begin
                    go     = 1'b1;
                    cmd.op = OP_PAGE;
                end
            end
        end
        if (last_cycle && cur_op == OP_MASS) clr_mass = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            cur_op <= OP_NONE;
        end else if (go) begin
            cnt    <= CNT_W'(ERASE_CYCLES);
            cur_op <= cmd.op;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (last_cycle) cur_op <= OP_NONE;
        end
    end

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int NUM_PAGES  = 32,
    localparam int DEPTH     = PAGE_BYTES * NUM_PAGES,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  erase_cmd_t        cmd,
    input  logic              prog_ok,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0]           mem [DEPTH];
    logic [NUM_PAGES-1:0] page_hit;

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page_sel
        assign page_hit[p] = go && (cmd.op == OP_MASS ||
                             (cmd.op == OP_PAGE && int'(cmd.page) == p));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (go) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (page_hit[i / PAGE_BYTES]) mem[i] <= 8'hFF;
            end
        end else if (prog_ok) begin
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES   = 32,
    parameter int NUM_PAGES    = 32,
    parameter int ERASE_CYCLES = 16,
    localparam int ADDR_W      = $clog2(PAGE_BYTES * NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              dbg_en,
    input  logic              cp_en,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              mass_armed
);

    logic              page_armed;
    logic [PAGE_W-1:0] page_sel;
    logic              clr_mass, clr_page;
    logic              go;
    erase_cmd_t        cmd;
    op_e               cur_op;
    logic              prog_ok;

    flash_seq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .sfr_we     (sfr_we),
        .sfr_addr   (sfr_addr),
        .ctrl_bit   (sfr_wdata[1]),
        .page_field (sfr_wdata[7:1]),
        .clr_mass   (clr_mass),
        .clr_page   (clr_page),
        .mass_armed (mass_armed),
        .page_armed (page_armed),
        .page_sel   (page_sel)
    );

    flash_seq_ctl #(
        .NUM_PAGES    (NUM_PAGES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .trig_we    (sfr_we && sfr_addr == SFR_TRIG),
        .trig_data  (sfr_wdata),
        .mass_armed (mass_armed),
        .page_armed (page_armed),
        .page_sel   (page_sel),
        .dbg_en     (dbg_en),
        .cp_en      (cp_en),
        .go         (go),
        .cmd        (cmd),
        .busy       (busy),
        .clr_mass   (clr_mass),
        .clr_page   (clr_page),
        .cur_op     (cur_op)
    );

    assign prog_ok = prog_we && !busy && !cp_en && !go;

    flash_seq_array #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cmd       (cmd),
        .prog_ok   (prog_ok),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int NUM_PAGES    = 32,
    parameter int ERASE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       mass_armed,
    input logic       go,
    input erase_cmd_t cmd,
    input op_e        cur_op,
    input logic       dbg_en,
    input logic       cp_en,
    input logic       sfr_we,
    input logic [7:0] sfr_addr,
    input logic [7:0] sfr_wdata
);

    int run;

    always_ff @(posedge clk) begin
        if (rst) run <= 0;
        else     run <= busy ? run + 1 : 0;
    end

    // R8
    busy_follows_go_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run == ERASE_CYCLES);

    // R9
    no_go_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !go);

    // R10
    no_go_with_cp_chk: assert property (@(posedge clk) disable iff (rst)
        cp_en |-> !go);

    // R5
    mass_needs_dbg_chk: assert property (@(posedge clk) disable iff (rst)
        (go && cmd.op == OP_MASS) |-> dbg_en);

    // R7
    page_range_chk: assert property (@(posedge clk) disable iff (rst)
        (go && cmd.op == OP_PAGE) |-> int'(cmd.page) < NUM_PAGES);

    // R6
    go_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> (sfr_we && sfr_addr == SFR_TRIG &&
               (sfr_wdata == KEY_MASS || sfr_wdata == KEY_PAGE)));

    // R11
    mass_arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(cur_op == OP_MASS) &&
         !$past(sfr_we && sfr_addr == SFR_CTRL)) |-> !mass_armed);

endmodule

bind flash_seq flash_seq_chk #(
    .NUM_PAGES    (NUM_PAGES),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mass_armed (mass_armed),
    .go         (go),
    .cmd        (cmd),
    .cur_op     (cur_op),
    .dbg_en     (dbg_en),
    .cp_en      (cp_en),
    .sfr_we     (sfr_we),
    .sfr_addr   (sfr_addr),
    .sfr_wdata  (sfr_wdata)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PB    = 32;
    localparam int NP    = 32;
    localparam int EC    = 16;
    localparam int DEPTH = PB * NP;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sfr_we = 1'b0;
    logic [7:0]    sfr_addr = '0;
    logic [7:0]    sfr_wdata = '0;
    logic          dbg_en = 1'b0;
    logic          cp_en = 1'b0;
    logic          prog_we = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [7:0]    prog_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, mass_armed;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    flash_seq #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .ERASE_CYCLES(EC)) u_dut (
        .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .dbg_en(dbg_en), .cp_en(cp_en),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .mass_armed(mass_armed)
    );

    // behavioural reference
    logic [7:0] m_mem [DEPTH];
    int         m_cnt;
    bit         m_mass_op, m_marm, m_parm;
    int         m_page;

    always @(posedge clk) begin
        bit was_busy, started;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_cnt = 0; m_mass_op = 0; m_marm = 0; m_parm = 0; m_page = 0;
        end else begin
            was_busy = (m_cnt != 0);
            started  = 0;
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0 && m_mass_op) m_marm = 0;
            end
            if (sfr_we && sfr_addr == 8'hB2) m_marm = sfr_wdata[1];
            if (sfr_we && sfr_addr == 8'hB7) begin
                m_page = int'(sfr_wdata[7:1]);
                m_parm = 1;
            end
            if (sfr_we && sfr_addr == 8'h94 && !was_busy) begin
                if (sfr_wdata == 8'hAA && m_marm) begin
                    if (dbg_en && !cp_en) begin
                        foreach (m_mem[i]) m_mem[i] = 8'hFF;
                        m_cnt = EC; m_mass_op = 1; started = 1;
                    end else m_marm = 0;
                end else if (sfr_wdata == 8'h55 && m_parm) begin
                    m_parm = 0;
                    if (m_page < NP && !cp_en) begin
                        for (int i = m_page * PB; i < (m_page + 1) * PB; i++) m_mem[i] = 8'hFF;
                        m_cnt = EC; m_mass_op = 0; started = 1;
                    end
                end
            end
            if (prog_we && !was_busy && !cp_en && !started)
                m_mem[prog_addr] = m_mem[prog_addr] & prog_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(busy == (m_cnt != 0), "R8 busy vs model", busy, m_cnt != 0);
            chk(mass_armed == m_marm, "R11 mass_armed vs model", mass_armed, m_marm);
            chk(rd_data == m_mem[rd_addr], "R2 R3 R4 array byte vs model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
        sfr_we = 1; sfr_addr = a; sfr_wdata = d;
        tick();
        sfr_we = 0;
    endtask

    task automatic prog(input int a, input logic [7:0] d);
        prog_we = 1; prog_addr = AW'(a); prog_data = d;
        tick();
        prog_we = 0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        rd_addr = AW'(a);
        tick();
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 200 && busy; g++) tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(mass_armed == 0, "R1 mass_armed after reset", mass_armed, 0);
        rd_chk(0, 8'hFF, "R1 first byte erased");
        rd_chk(DEPTH - 1, 8'hFF, "R1 last byte erased");

        // R2 bit-clearing program
        prog(5, 8'hF0);
        prog(5, 8'h3C);
        rd_chk(5, 8'h30, "R2 AND of two programs");
        prog(5, 8'hFF);
        rd_chk(5, 8'h30, "R2 bits cannot return to one");

        // R3 / R8 page erase
        prog(3 * PB + 7, 8'h12);
        prog(4 * PB, 8'h34);
        sfr_wr(8'hB7, 8'(3 << 1));
        sfr_wr(8'h94, 8'h55);
        n = 0;
        while (busy && n < 100) begin n++; tick(); end
        chk(n == EC, "R8 busy length", n, EC);
        rd_chk(3 * PB + 7, 8'hFF, "R3 byte of erased page");
        rd_chk(3 * PB, 8'hFF, "R3 first byte of erased page");
        rd_chk(4 * PB, 8'h34, "R3 neighbour page untouched");

        // R9 requests during busy
        prog(6 * PB, 8'h77);
        sfr_wr(8'hB7, 8'(4 << 1));
        sfr_wr(8'h94, 8'h55);
        chk(busy == 1, "R8 busy right after trigger", busy, 1);
        prog(5, 8'h00);
        sfr_wr(8'hB7, 8'(6 << 1));
        sfr_wr(8'h94, 8'h55);
        wait_idle();
        rd_chk(6 * PB, 8'h77, "R9 trigger during busy ignored");
        rd_chk(5, 8'h30, "R9 program during busy ignored");
        rd_chk(4 * PB, 8'hFF, "R3 page four erased");

        // R6 wrong keys (page 6 still armed)
        sfr_wr(8'h94, 8'h12);
        chk(busy == 0, "R6 bad key no busy", busy, 0);
        rd_chk(6 * PB, 8'h77, "R6 bad key no erase");
        sfr_wr(8'h94, 8'hAA);
        chk(busy == 0, "R6 mass key without mass arm", busy, 0);
        rd_chk(6 * PB, 8'h77, "R6 mass key without mass arm keeps data");
        sfr_wr(8'h94, 8'h55);
        chk(busy == 1, "R6 armed page key accepted", busy, 1);
        wait_idle();
        rd_chk(6 * PB, 8'hFF, "R6 armed page erased");
        prog(6 * PB + 8, 8'h01);
        sfr_wr(8'h94, 8'h55);
        chk(busy == 0, "R6 arming consumed", busy, 0);
        rd_chk(6 * PB + 8, 8'h01, "R6 second key without arm");

        // R7 page out of range
        sfr_wr(8'hB7, 8'(40 << 1));
        sfr_wr(8'h94, 8'h55);
        chk(busy == 0, "R7 page 40 no busy", busy, 0);
        rd_chk(5, 8'h30, "R7 page 40 no erase");

        // R10 coprocessor running
        prog(9 * PB + 2, 8'h11);
        cp_en = 1;
        prog(9 * PB + 2, 8'h00);
        rd_chk(9 * PB + 2, 8'h11, "R10 program blocked");
        sfr_wr(8'hB7, 8'(9 << 1));
        sfr_wr(8'h94, 8'h55);
        chk(busy == 0, "R10 erase blocked busy", busy, 0);
        rd_chk(9 * PB + 2, 8'h11, "R10 erase blocked data");
        cp_en = 0;

        // R5 mass erase refused without debug port
        sfr_wr(8'hB2, 8'h02);
        chk(mass_armed == 1, "R5 mass armed", mass_armed, 1);
        dbg_en = 0;
        sfr_wr(8'h94, 8'hAA);
        chk(mass_armed == 0, "R5 arm cleared on refusal", mass_armed, 0);
        chk(busy == 0, "R5 no busy", busy, 0);
        rd_chk(5, 8'h30, "R5 data kept");

        // R4 / R11 mass erase
        dbg_en = 1;
        sfr_wr(8'hB2, 8'h02);
        sfr_wr(8'h94, 8'hAA);
        chk(busy == 1, "R4 mass erase busy", busy, 1);
        chk(mass_armed == 1, "R11 arm held during erase", mass_armed, 1);
        rd_chk(5, 8'hFF, "R4 byte erased");
        rd_chk(9 * PB + 2, 8'hFF, "R4 other page erased");
        rd_chk(6 * PB + 8, 8'hFF, "R4 third page erased");
        wait_idle();
        chk(mass_armed == 0, "R11 arm cleared after erase", mass_armed, 0);

        repeat (2) tick();
        finish_run();
    end

endmodule